// File: doc/BRIEF.md
# Reset-Strap Mode Selector and Output Gate

This block decides, once per reset, which of three operating modes a mixed power-management / general-purpose I/O device runs in. It watches a mode strap and the host power-good level while the active-low reset is held. When reset is released it freezes the decoded mode. In the same window it records an 8-bit hardware identity from pin pull-ups and pull-downs. After release those pins may be reused as ordinary outputs, because the identity stays in the register.

The block also performs output gating. The core supplies one output enable per pin, for 20 pins. While power-good is low, the block forces every enable to zero, except those of the four power-control pins in the two power-management modes. The block also reports the default direction of the multiplexed event pin, which depends on the mode. Every strap and the power-good level pass through a two-stage synchronizer before they are used.

Top module: `strap_mode_ctrl`

## Requirements
- R1: With the mode strap at 0 during reset, the mode code is 2'b00 (GPIO-only, 20 general pins), and `pc_active_o` is 0.
- R2: With the mode strap at 1 and power-good at 0 during reset, the mode code is 2'b01 (power-management mode), and `pc_active_o` is 1.
- R3: With the mode strap at 1 and power-good at 1 during reset, the mode code is 2'b10 (alternate power-management mode), and `pc_active_o` is 1. The code 2'b11 never appears.
- R4: In mode 01 or 10, while the synchronized power-good is 0, enables 0 to 15 read 0 and enables 16 to 19 (the power-control group) follow `core_oe_i`.
- R5: In modes 00 and 10, `id_o` holds the identity strap value last sampled during reset. Strap changes after release do not alter it.
- R6: In mode 01 no identity is captured, and `id_o` reads 8'h00.
- R7: In mode 00, while the synchronized power-good is 0, all 20 enables, including bits 16 to 19, read 0.
- R8: `evt_out_dflt_o` is 1 (event pin defaults to output) in mode 01, and 0 (input) in modes 00 and 10.
- R9: Once reset is released, the mode code stays unchanged whatever the straps do, until reset is asserted again.
- R10: A strap change during reset reaches the mode code on the third rising clock edge. A power-good change reaches the gating on the second rising clock edge.
- R11: While the synchronized power-good is 1, `oe_o` equals `core_oe_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| mode_strap_i | input | 1 | Mode strap pin level |
| pwr_good_i | input | 1 | Host power-good level |
| id_strap_i | input | 8 | Identity strap pin levels |
| core_oe_i | input | 20 | Per-pin output enables from the core |
| mode_o | output | 2 | Mode code: 00 GPIO, 01 power-management, 10 alternate |
| pc_active_o | output | 1 | Pins 16 to 19 act as power-control outputs |
| id_o | output | 8 | Latched identity register |
| evt_out_dflt_o | output | 1 | Default direction of the event pin, 1 = output |
| oe_o | output | 20 | Gated output enables |

## Verification
A strap change is due at `mode_o` and `id_o` three rising edges after it is applied: two synchronizer stages and the capture register. A power-good change is due at `oe_o` after two edges. A change on `core_oe_i` passes straight through in the same cycle. The bench applies inputs 3 ns after each rising edge. A behavioural model advances on every rising edge with these same delays. Every output is compared with the model at the falling edge. Directed checks count edges explicitly around a strap change and a power-good change, and sample just before and just after the due edge.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    MODE_GPIO = 2'b00,
    MODE_PMU  = 2'b01,
    MODE_ALT  = 2'b10
  } opmode_e;

  function automatic opmode_e decode_mode(input logic strap, input logic pg);
    if (!strap)  return MODE_GPIO;
    else if (pg) return MODE_ALT;
    else         return MODE_PMU;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  // Not reset: the straps must keep flowing while reset is held.
  always_ff @(posedge clk) begin
    stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_s_i,
  input  logic            pg_s_i,
  input  logic [ID_W-1:0] id_s_i,
  output opmode_e         mode_o,
  output logic [ID_W-1:0] id_o
);

  logic [1:0]      rst_ff;
  logic            rst_done;
  logic            cap_en;
  opmode_e         mode_nxt, mode_q;
  logic [ID_W-1:0] id_nxt, id_q;

  // Reset is asserted asynchronously and released through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end

  assign rst_done = rst_ff[1];
  assign cap_en   = ~rst_done;

  always_comb begin
    mode_nxt = decode_mode(mode_s_i, pg_s_i);
    id_nxt   = (mode_nxt == MODE_PMU) ? '0 : id_s_i;
  end

  // The capture registers track the straps while reset is held and freeze at release.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      mode_q <= mode_nxt;
      id_q   <= id_nxt;
    end
  end

  assign mode_o = mode_q;
  assign id_o   = id_q;

  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_done) |-> $stable(mode_q));

  a_r5_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_done) |-> $stable(id_q));

  a_r3_no_code11: assert property (@(posedge clk) disable iff (!rst_done)
    logic'(mode_q[1] & mode_q[0]) == 1'b0);

  a_r6_pmu_id_zero: assert property (@(posedge clk) disable iff (!rst_done)
    (mode_q == MODE_PMU) |-> (id_q == '0));

endmodule

// File: rtl/oe_gate.sv
module oe_gate #(
  parameter int NUM_PINS = 20,
  parameter int PC_LSB   = 16,
  parameter int PC_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pg_s_i,
  input  logic                pc_active_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic [NUM_PINS-1:0] oe_o
);

  localparam int PC_MSB = PC_LSB + PC_W - 1;

  function automatic logic [NUM_PINS-1:0] pc_mask_f();
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int i = PC_LSB; i <= PC_MSB; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_PINS-1:0] PC_MASK = pc_mask_f();

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i >= PC_LSB && i <= PC_MSB) begin : g_pc
      assign oe_o[i] = core_oe_i[i] & (pg_s_i | pc_active_i);
    end else begin : g_gen
      assign oe_o[i] = core_oe_i[i] & pg_s_i;
    end
  end

  a_r4_nonpc_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s_i |-> ((oe_o & ~PC_MASK) == '0));

  a_r7_gpio_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_s_i && !pc_active_i) |-> (oe_o == '0));

  a_r11_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    pg_s_i |-> (oe_o == core_oe_i));

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import strap_pkg::*;
#(
  parameter int ID_W        = 8,
  parameter int NUM_PINS    = 20,
  parameter int PC_LSB      = 16,
  parameter int PC_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_strap_i,
  input  logic                pwr_good_i,
  input  logic [ID_W-1:0]     id_strap_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic [1:0]          mode_o,
  output logic                pc_active_o,
  output logic [ID_W-1:0]     id_o,
  output logic                evt_out_dflt_o,
  output logic [NUM_PINS-1:0] oe_o
);

  localparam int SW = ID_W + 2;

  logic [SW-1:0]   sync_d, sync_q;
  logic            mode_s, pg_s;
  logic [ID_W-1:0] id_s;
  opmode_e         mode_cur;

  assign sync_d = {pwr_good_i, mode_strap_i, id_strap_i};

  strap_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (sync_d),
    .q_o (sync_q)
  );

  assign pg_s   = sync_q[SW-1];
  assign mode_s = sync_q[SW-2];
  assign id_s   = sync_q[ID_W-1:0];

  strap_capture #(.ID_W(ID_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_s_i (mode_s),
    .pg_s_i   (pg_s),
    .id_s_i   (id_s),
    .mode_o   (mode_cur),
    .id_o     (id_o)
  );

  assign mode_o         = mode_cur;
  assign pc_active_o    = (mode_cur != MODE_GPIO);
  assign evt_out_dflt_o = (mode_cur == MODE_PMU);

  oe_gate #(.NUM_PINS(NUM_PINS), .PC_LSB(PC_LSB), .PC_W(PC_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_s_i      (pg_s),
    .pc_active_i (pc_active_o),
    .core_oe_i   (core_oe_i),
    .oe_o        (oe_o)
  );

endmodule

// File: tb/strap_mode_ctrl_bench.sv
`timescale 1ns/1ps
module strap_mode_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        mode_strap;
  logic        pwr_good;
  logic [7:0]  id_strap;
  logic [19:0] core_oe;
  logic [1:0]  mode_o;
  logic        pc_active_o;
  logic [7:0]  id_o;
  logic        evt_o;
  logic [19:0] oe_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 0;
  bit done = 0;

  // reference model state
  int rc = 0;
  bit s1m, s2m, s1p, s2p;
  bit [7:0] s1i, s2i;
  int mode_m = 0;
  bit [7:0] id_m;

  strap_mode_ctrl u_strap_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_strap_i(mode_strap), .pwr_good_i(pwr_good),
    .id_strap_i(id_strap), .core_oe_i(core_oe), .mode_o(mode_o),
    .pc_active_o(pc_active_o), .id_o(id_o), .evt_out_dflt_o(evt_o), .oe_o(oe_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: 2-edge synchronizer delay, capture while reset not yet released
  always @(posedge clk) begin
    if (!rst_n) rc = 0;
    if (rc < 2) begin
      mode_m = !s2m ? 0 : (s2p ? 2 : 1);
      id_m   = (mode_m == 1) ? 8'h00 : s2i;
    end
    s2m = s1m; s1m = mode_strap;
    s2p = s1p; s1p = pwr_good;
    s2i = s1i; s1i = id_strap;
    if (rst_n && rc < 2) rc++;
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [19:0] oe_exp;
      for (int i = 0; i < 20; i++)
        oe_exp[i] = core_oe[i] & (s2p | ((i >= 16) && (mode_m != 0)));
      chk(mode_m == 0 ? "R1" : (mode_m == 1 ? "R2" : "R3"), 32'(mode_o), 32'(mode_m));
      chk(mode_m == 0 ? "R1" : "R2/R3 pc", 32'(pc_active_o), 32'(mode_m != 0));
      chk(mode_m == 1 ? "R6" : "R5", 32'(id_o), 32'(id_m));
      chk("R8", 32'(evt_o), 32'(mode_m == 1));
      chk(s2p ? "R11" : (mode_m == 0 ? "R7" : "R4"), 32'(oe_o), 32'(oe_exp));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  initial begin
    rst_n = 0; mode_strap = 0; pwr_good = 0; id_strap = 8'hA5; core_oe = 20'hFFFFF;
    step(5);
    cmp_en = 1;
    // GPIO mode, released
    step(5); rst_n = 1; step(6);
    pwr_good = 1; core_oe = 20'hF0F0F; step(4);
    pwr_good = 0; step(4);
    // R9 / R5: straps change after release, nothing captured
    mode_strap = 1; pwr_good = 1; id_strap = 8'h3C; step(6);
    @(negedge clk);
    chk("R9", 32'(mode_o), 32'd0);
    chk("R5", 32'(id_o), 32'hA5);
    step(1);

    // PMU mode
    rst_n = 0; mode_strap = 1; pwr_good = 0; id_strap = 8'hFF; step(8);
    rst_n = 1; core_oe = 20'hFFFFF; step(6);
    @(negedge clk);
    chk("R2", 32'(mode_o), 32'd1);
    chk("R6", 32'(id_o), 32'h00);
    chk("R4", 32'(oe_o), 32'hF0000);
    // R10: power-good reaches gating on the second edge
    step(1);
    pwr_good = 1;
    repeat (2) @(negedge clk);
    chk("R10 pg early", 32'(oe_o), 32'hF0000);
    @(negedge clk);
    chk("R10 pg due", 32'(oe_o), 32'hFFFFF);
    step(1);
    core_oe = 20'h5A5A5; step(3);

    // R10: strap change during reset reaches mode on the third edge
    rst_n = 0; mode_strap = 0; pwr_good = 1; step(6);
    mode_strap = 1;
    repeat (3) @(negedge clk);
    chk("R10 strap early", 32'(mode_o), 32'd0);
    @(negedge clk);
    chk("R10 strap due", 32'(mode_o), 32'd2);
    // alternate mode with identity change mid-reset
    step(1); id_strap = 8'h5A; step(6);
    rst_n = 1; step(4);
    id_strap = 8'h00; pwr_good = 0; core_oe = 20'hFFFFF; step(6);
    @(negedge clk);
    chk("R3", 32'(mode_o), 32'd2);
    chk("R5", 32'(id_o), 32'h5A);
    chk("R8", 32'(evt_o), 32'd0);
    chk("R4", 32'(oe_o), 32'hF0000);
    step(2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule